// File: doc/BRIEF.md
# Dual-Granularity SPI Serial Clock Generator

This block produces the serial clock for one SPI master channel from the reference clock it runs on. It also produces two one-cycle strobes that tell a shift register when to drive the next bit and when to capture the incoming bit. The divide ratio is taken from a configuration word and an extension word. A granularity bit chooses between a power-of-two divider and a linear divider. The linear divider covers every integer ratio from 1 to 4096, and its 12-bit value is split between the two words.

The shift engine requests a word with a one-cycle `start`. The generator then runs the programmed number of serial clock periods, pulses `word_done` in the final cycle, and returns the serial clock to its idle level. The configuration is copied into shadow registers whenever no word is in flight. Writes made during a word therefore take effect only for the next word.

Top module: `spi_clkgen`

## Requirements
- R1: With `cfg_word[29]` clear, the serial clock period is 2^K reference cycles, where K = `cfg_word[5:2]` (0 to 15).
- R2: With `cfg_word[29]` set, the period is ({`ctl_word[15:8]`, `cfg_word[5:2]`} + 1) reference cycles, a ratio from 1 to 4096.
- R3: For a ratio R of 2 or more, the active phase of each period lasts floor(R/2) cycles and the idle-level phase lasts R - floor(R/2) cycles. The active level is the inverse of CPOL (`cfg_word[1]`). With CPHA (`cfg_word[0]`) clear, a period starts with its idle-level phase. With CPHA set, it starts with its active phase.
- R4: With a ratio of 1, the serial clock follows the reference clock while a word runs: it is at the active level while `clk` is high and at idle level while `clk` is low. `launch` and `sample` are then both high in every cycle of the word.
- R5: Each serial clock period carries exactly one `launch` pulse, in its first cycle, and exactly one `sample` pulse. With CPHA clear, `sample` comes on the cycle where the clock turns active. With CPHA set, it comes on the cycle where the clock turns back to idle.
- R6: Out of reset, and whenever `busy` is low, `sclk` rests at CPOL and no strobes are produced.
- R7: A word has N periods. N is `word_len` clamped to the range 4 to 32. `word_done` pulses together with the last cycle of period N, and the clock is idle in the cycle after.
- R8: Changes to `cfg_word` and `ctl_word` divider or mode fields while `busy` is high do not alter the word in flight.
- R9: While the enable bit (`ctl_word[0]`) is low, `start` is ignored. Clearing the enable bit during a word aborts it: from the next edge on, `busy` is low, `sclk` is idle and no strobes are produced.
- R10: A `start` seen at a clock edge raises `busy` after that edge, with `sclk` still idle. The first period's outputs appear after the following edge. `busy` falls one cycle after the last period's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Divider field [5:2], granularity [29], CPOL [1], CPHA [0] |
| ctl_word | input | 32 | Upper divider bits [15:8], enable [0] |
| word_len | input | 6 | Requested serial periods per word (clamped to 4..32) |
| start | input | 1 | One-cycle word request from the shift engine |
| sclk | output | 1 | Serial clock pin level |
| launch | output | 1 | Drive-next-bit strobe |
| sample | output | 1 | Capture-bit strobe |
| busy | output | 1 | High from word start until the clock is back at idle |
| word_done | output | 1 | Pulse on the last cycle of the word |

## Verification
The bench runs words in both divider modes, with even ratios (2, 4, 8, 64, 4096), odd ratios (3, 5) and ratio 1 reached from either mode. Even and odd ratios show whether the duty split rounds the right way, and ratio 1 shows whether the pass-through path is taken instead of the counter. Each ratio is paired with different CPOL and CPHA settings to separate the idle-first and active-first period shapes and the strobe positions. Word lengths below 4 and above 32 expose the clamp. A rewrite of the divider and polarity in mid-word, an enable drop in mid-word, and a start issued while disabled cover the freeze and abort paths.

// File: rtl/spi_clkgen_pkg.sv
package spi_clkgen_pkg;
  localparam int CLKD_W   = 4;
  localparam int EXT_W    = 8;
  localparam int FINE_W   = CLKD_W + EXT_W;
  localparam int EXP_MAX  = (1 << CLKD_W) - 1;
  localparam int RATIO_W  = ((EXP_MAX + 1) > (FINE_W + 1)) ? (EXP_MAX + 1) : (FINE_W + 1);
  localparam int LEN_W    = 6;
  localparam int MIN_BITS = 4;
  localparam int MAX_BITS = 32;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [LEN_W-1:0]   len_t;

  typedef struct packed {
    logic   cpol;
    logic   cpha;
    logic   pass;
    ratio_t ratio;
    ratio_t lo;
    ratio_t hi;
    len_t   nbits;
  } shadow_t;

  // Divide ratio from the two register fields.
  function automatic ratio_t ratio_of(input logic gran,
                                      input logic [CLKD_W-1:0] clkd,
                                      input logic [EXT_W-1:0] ext);
    ratio_t r;
    if (gran) r = ratio_t'({ext, clkd}) + ratio_t'(1);
    else      r = ratio_t'(1) << clkd;
    return r;
  endfunction

  // Active (non-idle) phase length: the shorter half for odd ratios.
  function automatic ratio_t active_len(input ratio_t r);
    return r >> 1;
  endfunction

  // Idle-level phase length: the longer half for odd ratios.
  function automatic ratio_t idle_len(input ratio_t r);
    return r - (r >> 1);
  endfunction

  function automatic len_t clamp_len(input len_t req);
    len_t n;
    if (req < len_t'(MIN_BITS))      n = len_t'(MIN_BITS);
    else if (req > len_t'(MAX_BITS)) n = len_t'(MAX_BITS);
    else                             n = req;
    return n;
  endfunction
endpackage

// File: rtl/spi_clkgen_cfg.sv
module spi_clkgen_cfg
  import spi_clkgen_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CLKD_LSB = 2,
  parameter int GRAN_BIT = 29,
  parameter int CPOL_BIT = 1,
  parameter int CPHA_BIT = 0,
  parameter int EXT_LSB  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic [WORD_W-1:0] ctl_word,
  input  len_t              word_len,
  output shadow_t           sh
);
  ratio_t r_next;

  always_comb
    r_next = ratio_of(cfg_word[GRAN_BIT], cfg_word[CLKD_LSB +: CLKD_W],
                      ctl_word[EXT_LSB +: EXT_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh.cpol  <= 1'b0;
      sh.cpha  <= 1'b0;
      sh.pass  <= 1'b1;
      sh.ratio <= ratio_t'(1);
      sh.lo    <= ratio_t'(1);
      sh.hi    <= '0;
      sh.nbits <= len_t'(MIN_BITS);
    end else if (load) begin
      sh.cpol  <= cfg_word[CPOL_BIT];
      sh.cpha  <= cfg_word[CPHA_BIT];
      sh.pass  <= (r_next == ratio_t'(1));
      sh.ratio <= r_next;
      sh.lo    <= idle_len(r_next);
      sh.hi    <= active_len(r_next);
      sh.nbits <= clamp_len(word_len);
    end
  end
endmodule

// File: rtl/spi_clkgen_seq.sv
module spi_clkgen_seq
  import spi_clkgen_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   start,
  input  ratio_t ratio,
  input  len_t   nbits,
  output logic   run,
  output ratio_t pos,
  output logic   period_end,
  output logic   word_end
);
  len_t bitc;

  assign period_end = run && (pos == ratio - ratio_t'(1));
  assign word_end   = period_end && (bitc == nbits - len_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      pos  <= '0;
      bitc <= '0;
    end else if (!en) begin
      run  <= 1'b0;
      pos  <= '0;
      bitc <= '0;
    end else if (!run) begin
      if (start) begin
        run  <= 1'b1;
        pos  <= '0;
        bitc <= '0;
      end
    end else if (period_end) begin
      pos <= '0;
      if (word_end) run  <= 1'b0;
      else          bitc <= bitc + len_t'(1);
    end else begin
      pos <= pos + ratio_t'(1);
    end
  end
endmodule

// File: rtl/spi_clkgen_out.sv
module spi_clkgen_out
  import spi_clkgen_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    run,
  input  ratio_t  pos,
  input  logic    word_end,
  input  shadow_t sh,
  output logic    sclk,
  output logic    launch,
  output logic    sample,
  output logic    word_done,
  output logic    out_busy
);
  logic   live;
  logic   act;
  ratio_t samp_pos;
  logic   sclk_q;
  logic   pass_q;

  assign live = run && en;

  always_comb begin
    act      = sh.cpha ? (pos < sh.hi) : (pos >= sh.lo);
    samp_pos = sh.pass ? '0 : (sh.cpha ? sh.hi : sh.lo);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      pass_q    <= 1'b0;
      launch    <= 1'b0;
      sample    <= 1'b0;
      word_done <= 1'b0;
      out_busy  <= 1'b0;
    end else begin
      sclk_q    <= sh.cpol ^ (live && act);
      pass_q    <= live && sh.pass;
      launch    <= live && (pos == '0);
      sample    <= live && (pos == samp_pos);
      word_done <= live && word_end;
      out_busy  <= live;
    end
  end

  // Ratio 1: the reference itself, gated by a registered enable.
  assign sclk = sclk_q ^ (pass_q & clk);
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_clkgen_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CLKD_LSB = 2,
  parameter int GRAN_BIT = 29,
  parameter int CPOL_BIT = 1,
  parameter int CPHA_BIT = 0,
  parameter int EXT_LSB  = 8,
  parameter int EN_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              start,
  output logic              sclk,
  output logic              launch,
  output logic              sample,
  output logic              busy,
  output logic              word_done
);
  shadow_t sh;
  logic    en;
  logic    run;
  ratio_t  pos;
  ratio_t  cur_ratio;
  logic    period_end;
  logic    word_end;
  logic    out_busy;
  logic    unused_field_bits;

  assign en                = ctl_word[EN_BIT];
  assign cur_ratio         = sh.ratio;
  assign busy              = run | out_busy;
  assign unused_field_bits = ^{cfg_word, ctl_word, period_end};

  spi_clkgen_cfg #(
    .WORD_W(WORD_W), .CLKD_LSB(CLKD_LSB), .GRAN_BIT(GRAN_BIT),
    .CPOL_BIT(CPOL_BIT), .CPHA_BIT(CPHA_BIT), .EXT_LSB(EXT_LSB)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(!run), .cfg_word(cfg_word),
    .ctl_word(ctl_word), .word_len(word_len), .sh(sh)
  );

  spi_clkgen_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .ratio(sh.ratio),
    .nbits(sh.nbits), .run(run), .pos(pos), .period_end(period_end),
    .word_end(word_end)
  );

  spi_clkgen_out u_out (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run), .pos(pos),
    .word_end(word_end), .sh(sh), .sclk(sclk), .launch(launch),
    .sample(sample), .word_done(word_done), .out_busy(out_busy)
  );
endmodule

// File: rtl/spi_clkgen_chk.sv
module spi_clkgen_chk
  import spi_clkgen_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   en,
  input logic   run,
  input logic   busy,
  input logic   launch,
  input logic   sample,
  input logic   word_done,
  input logic   word_end,
  input ratio_t pos,
  input ratio_t cur_ratio
);
  // R5
  launch_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch || sample) |-> busy);

  // R5
  period_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en && pos == '0) |=> launch);

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!launch && !sample && !word_done));

  // R8
  frozen_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(cur_ratio));

  // R7
  word_end_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> !run);

  // R7
  done_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> busy);
endmodule

bind spi_clkgen spi_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .run(run), .busy(busy),
  .launch(launch), .sample(sample), .word_done(word_done),
  .word_end(word_end), .pos(pos), .cur_ratio(cur_ratio)
);

// File: tb/tb_spi_clkgen.sv
module tb_spi_clkgen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_word;
  logic [31:0] ctl_word;
  logic [5:0]  word_len;
  logic        start;
  logic        sclk, launch, sample, busy, word_done;

  always #2 clk = ~clk;

  spi_clkgen dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .ctl_word(ctl_word),
    .word_len(word_len), .start(start), .sclk(sclk), .launch(launch),
    .sample(sample), .busy(busy), .word_done(word_done)
  );

  typedef struct {
    logic  sclk;
    logic  launch;
    logic  sample;
    logic  done;
    logic  busy;
    string req;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  // Monitor: one expected item per cycle, sampled after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        item_t e;
        e = exp_q.pop_front();
        checks++;
        if ({sclk, launch, sample, word_done, busy} !==
            {e.sclk, e.launch, e.sample, e.done, e.busy}) begin
          errors++;
          $display("FAIL %s sclk/launch/sample/done/busy: got %b%b%b%b%b expected %b%b%b%b%b",
                   e.req, sclk, launch, sample, word_done, busy,
                   e.sclk, e.launch, e.sample, e.done, e.busy);
        end
      end
    end
  end

  function automatic item_t mk(input logic s, l, m, d, b, input string req);
    item_t it;
    it.sclk = s; it.launch = l; it.sample = m; it.done = d; it.busy = b;
    it.req = req;
    return it;
  endfunction

  // Driver: program, push the expected waveform, issue the request.
  task automatic run_word(input bit gran, input int clkd, input int ext,
                          input bit cpol, input bit cpha, input int len_req,
                          input string req, input bit disturb);
    int r, n, hi, lo;
    @(negedge clk);
    cfg_word       = '0;
    cfg_word[5:2]  = clkd[3:0];
    cfg_word[29]   = gran;
    cfg_word[1]    = cpol;
    cfg_word[0]    = cpha;
    ctl_word       = '0;
    ctl_word[15:8] = ext[7:0];
    ctl_word[0]    = 1'b1;
    word_len       = len_req[5:0];
    repeat (3) @(negedge clk);
    r  = gran ? (ext * 16 + clkd + 1) : (1 << clkd);
    n  = (len_req < 4) ? 4 : ((len_req > 32) ? 32 : len_req);
    hi = r / 2;
    lo = r - hi;
    exp_q.push_back(mk(cpol, 0, 0, 0, 1, "R10 lead"));
    for (int b = 0; b < n; b++) begin
      for (int p = 0; p < r; p++) begin
        bit a, sm;
        a  = (r == 1) ? 1'b1 : (cpha ? (p < hi) : (p >= lo));
        sm = (r == 1) ? 1'b1 : (cpha ? (p == hi) : (p == lo));
        exp_q.push_back(mk(cpol ^ a, p == 0, sm, (b == n - 1) && (p == r - 1),
                           1, req));
      end
    end
    exp_q.push_back(mk(cpol, 0, 0, 0, 0, "R10 tail"));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (3) @(negedge clk);
      cfg_word[5:2]  = ~clkd[3:0];
      cfg_word[1]    = ~cpol;
      ctl_word[15:8] = ~ext[7:0];
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_word = '0; ctl_word = '0; word_len = 6'd8; start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R6", "reset sclk", sclk, 1'b0);
    check("R6", "reset busy", busy, 1'b0);
    check("R6", "reset launch", launch, 1'b0);
    check("R6", "reset sample", sample, 1'b0);

    run_word(0, 3, 0, 0, 0, 8,  "R1 R3 R5 coarse 8", 0);
    run_word(0, 6, 0, 0, 1, 4,  "R1 R3 R5 coarse 64 cpha", 0);
    run_word(0, 0, 0, 1, 0, 5,  "R4 coarse ratio 1", 0);
    run_word(1, 4, 0, 1, 1, 6,  "R2 R3 fine odd 5", 0);
    run_word(1, 15, 255, 0, 0, 4, "R2 fine 4096", 0);
    run_word(1, 0, 0, 1, 1, 4,  "R4 fine ratio 1", 0);
    run_word(1, 3, 0, 0, 1, 4,  "R3 R5 even 4 cpha", 0);
    run_word(1, 2, 0, 1, 0, 2,  "R7 clamp low", 0);
    run_word(1, 1, 0, 0, 0, 40, "R7 clamp high", 0);
    run_word(1, 5, 0, 1, 0, 6,  "R8 frozen config", 1);

    // R6: idle level tracks CPOL while no word runs
    @(negedge clk); cfg_word = '0; cfg_word[1] = 1'b1;
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    check("R6", "idle high sclk", sclk, 1'b1);
    check("R6", "idle busy", busy, 1'b0);

    // R9: abort by clearing enable mid-word
    @(negedge clk);
    cfg_word = '0; cfg_word[29] = 1'b1; cfg_word[5:2] = 4'd7; cfg_word[1] = 1'b1;
    ctl_word = 32'h1; word_len = 6'd8;
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    check("R9", "running before abort", busy, 1'b1);
    ctl_word[0] = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      check("R9", "abort busy", busy, 1'b0);
      check("R9", "abort sclk idle", sclk, 1'b1);
      check("R9", "abort launch", launch, 1'b0);
      check("R9", "abort sample", sample, 1'b0);
    end

    // R9: start ignored while disabled
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check("R9", "disabled start busy", busy, 1'b0);
      check("R9", "disabled start launch", launch, 1'b0);
    end

    run_word(1, 7, 0, 0, 0, 4, "R9 recovery after enable", 0);
    finish_run();
  end
endmodule